// File: doc/BRIEF.md
# Horizontal Pixel Scaler

This block resamples a stream of RGB pixels along each line by a programmable ratio between 1/32 and 32. Pixels enter one at a time on a valid/ready stream, and a flag marks the last pixel of each line. Resampled pixels leave on a second valid/ready stream, and a flag marks the first output pixel of each line. Only one ratio is in force at a time, so a line is either enlarged or reduced, never both.

A position accumulator with six fractional bits advances by a step value for every output pixel. Its integer part counts the input pixels still to skip. Its fraction is the phase that weights the two neighbouring input pixels A and B. Three filters are available: pass-through, nearest-neighbour duplicate, and bilinear blend with rounding. At the end of a line, B is clamped to A, so no pixel of the following line leaks into the current one. The position restarts at zero for every line.

Top module: `pix_hscaler`

## Requirements
- R1: After reset `out_valid_o` is low and `in_ready_o` is high.
- R2: With `mode_i` = 0 (pass), every input pixel appears unchanged on the output, once and in order, whatever the value of `step_i`.
- R3: With `mode_i` = 1 (duplicate), each output equals A when the phase is below 32 and equals B otherwise.
- R4: With `mode_i` = 2 or 3 (bilinear), each channel is ((64 - phase)*A + phase*B + 32) >> 6. The channels are red [23:16], green [15:8] and blue [7:0], and each is computed separately.
- R5: Output k of a line sits at position k*step in 1/64 pixel units. The integer part selects A (input index i) and the fraction is the phase. A line of N inputs yields exactly the outputs with i <= N-1, and no more.
- R6: Outside pass mode the step is limited to 2..2048 (ratio 32 down to 1/32). Smaller values act as 2 and larger values act as 2048.
- R7: When A is the last pixel of a line, B is taken equal to A. A line of one pixel yields copies of that pixel.
- R8: `out_sol_o` is high on the first output pixel of every line and low on all others.
- R9: While `out_valid_o` is high and `out_ready_i` is low, the output pixel and its flag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Filter: 0 pass, 1 duplicate, 2/3 bilinear |
| step_i | input | 12 | Position increment per output pixel, 6 fractional bits |
| in_valid_i | input | 1 | Input pixel valid |
| in_pix_i | input | 24 | Input pixel, R/G/B 8 bits each |
| in_last_i | input | 1 | Input pixel is the last of its line |
| in_ready_o | output | 1 | Input pixel accepted when high with valid |
| out_valid_o | output | 1 | Output pixel valid |
| out_pix_o | output | 24 | Output pixel |
| out_sol_o | output | 1 | Output pixel is the first of its line |
| out_ready_i | input | 1 | Downstream accepts the output pixel |

## Verification
An input pixel is accepted at the clock edge where valid and ready are both high. The output register loads one edge after the two-pixel window and the zero skip count permit it. The result therefore depends on handshakes and not on a fixed latency. The bench never predicts a cycle. It samples both streams at the falling edge, treats a pixel as taken only when `out_valid_o` and the `out_ready_i` it drives for that same cycle are both high, and matches the k-th taken pixel against the arithmetic model. A stalled pixel is compared on the next falling edge against the value held one cycle earlier. A few idle cycles after each line confirm that no surplus pixel follows.

// File: rtl/pix_hscaler_pkg.sv
`timescale 1ns/1ps
package pix_hscaler_pkg;
  typedef enum logic [1:0] {
    HS_PASS  = 2'd0,
    HS_DUP   = 2'd1,
    HS_BILIN = 2'd2,
    HS_BILX  = 2'd3
  } hs_mode_e;
endpackage

// File: rtl/hs_window.sv
`timescale 1ns/1ps
// Two-pixel window: A is the current pixel, B is its right neighbour.
module hs_window #(
  parameter int PIX_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [PIX_W-1:0] in_pix_i,
  input  logic             in_last_i,
  output logic             in_ready_o,
  input  logic             advance_i,
  output logic             a_vld_o,
  output logic [PIX_W-1:0] a_pix_o,
  output logic             a_last_o,
  output logic             b_vld_o,
  output logic [PIX_W-1:0] b_pix_o
);
  logic b_last;

  // B is never filled past the end of a line
  assign in_ready_o = !a_vld_o || (!b_vld_o && !a_last_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_vld_o  <= 1'b0;
      a_pix_o  <= '0;
      a_last_o <= 1'b0;
      b_vld_o  <= 1'b0;
      b_pix_o  <= '0;
      b_last   <= 1'b0;
    end else if (advance_i) begin
      if (a_last_o) begin
        a_vld_o  <= 1'b0;
        a_last_o <= 1'b0;
      end else begin
        a_vld_o  <= b_vld_o;
        a_pix_o  <= b_pix_o;
        a_last_o <= b_last;
        b_vld_o  <= 1'b0;
      end
    end else if (in_valid_i && in_ready_o) begin
      if (!a_vld_o) begin
        a_vld_o  <= 1'b1;
        a_pix_o  <= in_pix_i;
        a_last_o <= in_last_i;
      end else begin
        b_vld_o <= 1'b1;
        b_pix_o <= in_pix_i;
        b_last  <= in_last_i;
      end
    end
  end
endmodule

// File: rtl/hs_blend_ch.sv
`timescale 1ns/1ps
module hs_blend_ch
  import pix_hscaler_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int FRAC_W = 6
) (
  input  logic [CH_W-1:0]   a_i,
  input  logic [CH_W-1:0]   b_i,
  input  logic [FRAC_W-1:0] ph_i,
  input  hs_mode_e          mode_i,
  output logic [CH_W-1:0]   y_o
);
  // (2^F)(2^C-1) + 2^(F-1) fits in C+F bits
  localparam int SUM_W = CH_W + FRAC_W;

  logic [FRAC_W:0]  ph_x, inv;
  logic [SUM_W-1:0] sum;
  logic [CH_W-1:0]  bilin;

  always_comb begin
    ph_x  = {1'b0, ph_i};
    inv   = (FRAC_W+1)'(1 << FRAC_W) - ph_x;
    sum   = SUM_W'(inv) * SUM_W'(a_i) + SUM_W'(ph_x) * SUM_W'(b_i)
          + SUM_W'(1 << (FRAC_W-1));
    bilin = CH_W'(sum >> FRAC_W);
    case (mode_i)
      HS_PASS: y_o = a_i;
      HS_DUP:  y_o = ph_i[FRAC_W-1] ? b_i : a_i;
      default: y_o = bilin;
    endcase
  end
endmodule

// File: rtl/pix_hscaler.sv
`timescale 1ns/1ps
module pix_hscaler
  import pix_hscaler_pkg::*;
#(
  parameter int CH_W     = 8,
  parameter int NUM_CH   = 3,
  parameter int FRAC_W   = 6,
  parameter int STEP_W   = 12,
  parameter int STEP_MIN = 2,
  parameter int STEP_MAX = 2048
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               mode_i,
  input  logic [STEP_W-1:0]        step_i,
  input  logic                     in_valid_i,
  input  logic [CH_W*NUM_CH-1:0]   in_pix_i,
  input  logic                     in_last_i,
  output logic                     in_ready_o,
  output logic                     out_valid_o,
  output logic [CH_W*NUM_CH-1:0]   out_pix_o,
  output logic                     out_sol_o,
  input  logic                     out_ready_i
);
  localparam int PIX_W = CH_W * NUM_CH;
  localparam int ACC_W = STEP_W + 1;
  localparam int INT_W = ACC_W - FRAC_W;
  localparam logic [ACC_W-1:0] ONE = ACC_W'(1 << FRAC_W);

  hs_mode_e mode;
  logic [ACC_W-1:0]  acc, step_eff;
  logic [INT_W-1:0]  acc_int;
  logic [FRAC_W-1:0] phase;
  logic a_vld, a_last, b_vld, win_ok, advance, emit, sol_pend;
  logic [PIX_W-1:0] a_pix, b_pix, b_sel, blend_pix;

  assign mode    = hs_mode_e'(mode_i);
  assign acc_int = acc[ACC_W-1:FRAC_W];
  assign phase   = acc[FRAC_W-1:0];

  always_comb begin
    if (mode == HS_PASS)                    step_eff = ONE;
    else if (step_i < STEP_W'(STEP_MIN))    step_eff = ACC_W'(STEP_MIN);
    else if (step_i > STEP_W'(STEP_MAX))    step_eff = ACC_W'(STEP_MAX);
    else                                    step_eff = ACC_W'(step_i);
  end

  hs_window #(.PIX_W(PIX_W)) i_window (
    .clk_i, .rst_ni, .in_valid_i, .in_pix_i, .in_last_i, .in_ready_o,
    .advance_i (advance),
    .a_vld_o   (a_vld),
    .a_pix_o   (a_pix),
    .a_last_o  (a_last),
    .b_vld_o   (b_vld),
    .b_pix_o   (b_pix)
  );

  assign win_ok  = a_vld && (b_vld || a_last);
  assign advance = win_ok && (acc_int != '0);
  assign emit    = win_ok && (acc_int == '0) && (!out_valid_o || out_ready_i);
  assign b_sel   = a_last ? a_pix : b_pix;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    hs_blend_ch #(.CH_W(CH_W), .FRAC_W(FRAC_W)) i_blend (
      .a_i    (a_pix[c*CH_W +: CH_W]),
      .b_i    (b_sel[c*CH_W +: CH_W]),
      .ph_i   (phase),
      .mode_i (mode),
      .y_o    (blend_pix[c*CH_W +: CH_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc      <= '0;
      sol_pend <= 1'b1;
    end else if (advance) begin
      acc      <= a_last ? '0 : acc - ONE;
      sol_pend <= a_last ? 1'b1 : sol_pend;
    end else if (emit) begin
      acc      <= acc + step_eff;
      sol_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_pix_o   <= '0;
      out_sol_o   <= 1'b0;
    end else if (emit) begin
      out_valid_o <= 1'b1;
      out_pix_o   <= blend_pix;
      out_sol_o   <= sol_pend;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pix_hscaler_chk.sv
`timescale 1ns/1ps
module pix_hscaler_chk #(
  parameter int CH_W     = 8,
  parameter int NUM_CH   = 3,
  parameter int FRAC_W   = 6,
  parameter int STEP_W   = 12,
  parameter int STEP_MAX = 2048
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [1:0]               mode_i,
  input logic                     in_ready_o,
  input logic                     out_valid_o,
  input logic                     out_ready_i,
  input logic [CH_W*NUM_CH-1:0]   out_pix_o,
  input logic                     out_sol_o,
  input logic                     a_vld,
  input logic                     a_last,
  input logic [CH_W*NUM_CH-1:0]   a_pix,
  input logic [CH_W*NUM_CH-1:0]   b_sel,
  input logic [CH_W*NUM_CH-1:0]   blend_pix,
  input logic                     emit,
  input logic [STEP_W-FRAC_W:0]   acc_int
);
  logic [NUM_CH-1:0] span_ok;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_span
    logic [CH_W-1:0] a, b, y;
    assign a = a_pix[c*CH_W +: CH_W];
    assign b = b_sel[c*CH_W +: CH_W];
    assign y = blend_pix[c*CH_W +: CH_W];
    assign span_ok[c] = (y >= a && y <= b) || (y >= b && y <= a);
  end

  // R9
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_pix_o) && $stable(out_sol_o));

  // R6
  skip_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_int <= (STEP_W-FRAC_W+1)'(STEP_MAX >> FRAC_W));

  // R4
  bilin_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit && mode_i[1] |-> &span_ok);

  // R3
  dup_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit && mode_i == 2'd1 |-> (blend_pix == a_pix) || (blend_pix == b_sel));

  // R7
  line_end_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_vld && a_last |-> !in_ready_o);
endmodule

bind pix_hscaler pix_hscaler_chk #(
  .CH_W(CH_W), .NUM_CH(NUM_CH), .FRAC_W(FRAC_W), .STEP_W(STEP_W), .STEP_MAX(STEP_MAX)
) i_pix_hscaler_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_pix_o   (out_pix_o),
  .out_sol_o   (out_sol_o),
  .a_vld       (a_vld),
  .a_last      (a_last),
  .a_pix       (a_pix),
  .b_sel       (b_sel),
  .blend_pix   (blend_pix),
  .emit        (emit),
  .acc_int     (acc_int)
);

// File: tb/test_pix_hscaler.sv
`timescale 1ns/1ps
module test_pix_hscaler;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [11:0] step_i = 12'd64;
  logic        in_valid_i = 1'b0;
  logic [23:0] in_pix_i = '0;
  logic        in_last_i = 1'b0;
  logic        in_ready_o;
  logic        out_valid_o;
  logic [23:0] out_pix_o;
  logic        out_sol_o;
  logic        out_ready_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  logic [23:0] line_px [64];

  always #10 clk_i = ~clk_i;

  pix_hscaler i_pix_hscaler (.*);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] mk_px(input int i, input int seed);
    if (seed % 3 == 0) return (i % 2 == 1) ? 24'hFFFFFF : 24'h000000;
    return {8'((i*37 + seed*11) & 255), 8'((i*113 + seed*7 + 5) & 255), 8'((255 - i*29 - seed) & 255)};
  endfunction

  function automatic logic [23:0] model(input int mode, input logic [23:0] a, input logic [23:0] b, input int ph);
    logic [23:0] r;
    if (mode == 0) return a;
    if (mode == 1) return (ph < 32) ? a : b;
    for (int c = 0; c < 3; c++)
      r[c*8 +: 8] = 8'(((64 - ph) * int'(a[c*8 +: 8]) + ph * int'(b[c*8 +: 8]) + 32) / 64);
    return r;
  endfunction

  task automatic send_line(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      in_valid_i = 1'b1;
      in_pix_i   = line_px[i];
      in_last_i  = (i == n-1);
      while (!in_ready_o) @(negedge clk_i);
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    in_last_i  = 1'b0;
  endtask

  task automatic recv_line(input int mode, input int st, input int n, input int n_exp, input string tag);
    int k = 0;
    logic stalled = 1'b0;
    logic [23:0] held = '0;
    while (k < n_exp) begin
      @(negedge clk_i);
      if (stalled)
        chk(out_valid_o && out_pix_o == held, "R9 hold", 32'(out_pix_o), 32'(held));
      out_ready_i = ($urandom % 4) != 0;
      if (out_valid_o && out_ready_i) begin
        int pos = k * st;
        int i = pos / 64;
        int ph = pos % 64;
        logic [23:0] a = line_px[i];
        logic [23:0] b = line_px[(i+1 < n) ? i+1 : n-1];
        logic [23:0] e = model(mode, a, b, ph);
        string t = (i == n-1 && ph != 0 && mode != 0) ? {tag, "/R7"} : tag;
        chk(out_pix_o == e, t, 32'(out_pix_o), 32'(e));
        chk(out_sol_o == (k == 0), "R8 sol", 32'(out_sol_o), 32'(k == 0));
        k++;
      end
      stalled = out_valid_o && !out_ready_i;
      held = out_pix_o;
    end
  endtask

  task automatic run_line(input int mode, input int step, input int n, input int seed, input string tag);
    int st, n_exp;
    @(negedge clk_i);
    mode_i = 2'(mode);
    step_i = 12'(step);
    for (int i = 0; i < n; i++) line_px[i] = mk_px(i, seed);
    st = (mode == 0) ? 64 : (step < 2) ? 2 : (step > 2048) ? 2048 : step;
    n_exp = 0;
    while (n_exp * st < n * 64) n_exp++;
    fork
      send_line(n);
      recv_line(mode == 3 ? 2 : mode, st, n, n_exp, tag);
    join
    out_ready_i = 1'b1;
    repeat (4) @(negedge clk_i);
    // R5: nothing beyond the expected count
    chk(!out_valid_o, "R5 surplus", 32'(out_valid_o), 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int steps [12] = '{2, 5, 32, 45, 63, 64, 65, 100, 127, 128, 640, 2048};
    repeat (3) @(negedge clk_i);
    // R1
    chk(out_valid_o == 1'b0, "R1 out_valid", 32'(out_valid_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(in_ready_o == 1'b1, "R1 in_ready", 32'(in_ready_o), 32'd1);
    chk(out_valid_o == 1'b0, "R1 idle", 32'(out_valid_o), 32'd0);

    // R2: step ignored in pass mode
    run_line(0, 100, 17, 1, "R2");
    run_line(0, 0, 9, 3, "R2");
    run_line(0, 4095, 12, 2, "R2");

    for (int m = 1; m <= 2; m++)
      for (int s = 0; s < 12; s++)
        run_line(m, steps[s], 9 + (s % 5), s + m, m == 1 ? "R3" : "R4");

    run_line(3, 45, 10, 4, "R4");
    run_line(2, 1, 3, 3, "R4");
    run_line(2, 19, 5, 0, "R4");

    // R6: clamping of the step
    run_line(2, 0, 4, 5, "R6");
    run_line(1, 1, 4, 7, "R6");
    run_line(2, 3000, 70 > 64 ? 64 : 64, 8, "R6");
    run_line(1, 4095, 40, 10, "R6");

    // R7: single-pixel lines
    run_line(2, 7, 1, 11, "R7");
    run_line(1, 20, 1, 13, "R7");
    run_line(2, 2048, 1, 14, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule